// File: doc/BRIEF.md
# Active Priority Preemption Tracker

This block keeps the preemption state of one processor interface of an interrupt controller. Each preemption level is one bit, in one of two banks: a bank for secure group 0 interrupts and a bank for non-secure group 1 interrupts. The block also produces the running priority. This is the priority below which a new interrupt may preempt the handler that is running now.

**Acknowledge.** When an interrupt is acknowledged, the block masks the interrupt's 8-bit priority with the selected binary point to form a group priority. It sets the bit for that group priority's preemption level in the bank of the interrupt's group. The running priority then becomes that group priority.

**End-of-interrupt.** When a handler completes, the block clears the most urgent bit in that group's bank. It then rebuilds the running priority from the lowest set bit across both banks. The state is a bitmap, not a stack of interrupt IDs, so nesting depth needs no extra storage.

Top module: `apt_tracker`

## Requirements
- R1: After reset, `run_prio` is 0x100 (idle) and every bit of `sec_active` and `ns_active` is 0.
- R2: One cycle after an `ack_valid` strobe, `run_prio` equals `ack_prio & (0xFF << (B+1))`, where B is the selected binary point (0 keeps bits [7:1], 7 gives 0).
- R3: B is `bpr_alias` when `groups_en` is 1, `common_bpr` is 0 and `ack_group1` is 1. In every other case B is `bpr_main`.
- R4: An acknowledge sets bit L = groupprio >> (MIN_BPR+1) of the flat bank vector (word L/32, bit L%32). It uses `ns_active` when `groups_en & ack_group1` is 1, and `sec_active` otherwise.
- R5: An accepted end-of-interrupt clears only the lowest set bit of the first nonzero 32-bit word of the bank of group `groups_en & eoi_group1`. The other bank is unchanged.
- R6: After an accepted end-of-interrupt, `run_prio` = (index of the lowest set bit of `sec_active | ns_active`) << (MIN_BPR+1). If both banks are empty, it is 0x100.
- R7: An end-of-interrupt with `eoi_id` >= NUM_IRQ changes no output.
- R8: An end-of-interrupt while `run_prio` is 0x100 changes no output.
- R9: An end-of-interrupt with `eoi_nonsecure` = 1 for a group 0 interrupt changes no output. This includes the case where `groups_en` = 0 forces the group to 0.
- R10: When both strobes are high in the same cycle, only the acknowledge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| groups_en | input | 1 | Interrupt groups implemented |
| common_bpr | input | 1 | Group 1 uses the main binary point |
| bpr_main | input | 3 | Main binary point |
| bpr_alias | input | 3 | Binary point for group 1 |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| ack_group1 | input | 1 | Acknowledged interrupt is group 1 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | ID_W | Interrupt ID being completed |
| eoi_group1 | input | 1 | Completed interrupt is group 1 |
| eoi_nonsecure | input | 1 | End-of-interrupt comes from a non-secure access |
| run_prio | output | 9 | Running priority, 0x100 when idle |
| sec_active | output | NB | Group 0 active-level bank, flat words |
| ns_active | output | NB | Group 1 active-level bank, flat words |

## Verification
The hardest state to reach is a deep nesting where the active levels of the two groups interleave across different 32-bit words. Only then does an end-of-interrupt in one group leave a lower set bit in the other bank, which must set the new running priority. The bench builds this state with three acknowledges at priorities 0x80 (group 0), 0x40 (group 1) and 0x20 (group 0), which land in words 2, 1 and 0. It then unwinds them one group at a time and compares each step against a bit-level model of both banks.

// File: rtl/apt_pkg.sv
package apt_pkg;
    localparam logic [8:0] APT_IDLE = 9'h100;

    // number of 32-bit active words for a given minimum binary point
    function automatic int apt_words(int min_bpr);
        int w;
        w = 128 >> (min_bpr + 5);
        return (w < 1) ? 1 : w;
    endfunction
endpackage

// File: rtl/apt_group_prio.sv
module apt_group_prio #(
    parameter int MIN_BPR = 0,
    parameter int LVL_W   = 7
) (
    input  logic [7:0]       prio,
    input  logic [2:0]       bpr,
    output logic [7:0]       gprio,
    output logic [LVL_W-1:0] level
);
    localparam int SH = MIN_BPR + 1;

    logic [7:0] mask;

    always_comb begin
        mask  = 8'hFF << (int'(bpr) + 1);
        gprio = prio & mask;
        level = LVL_W'(gprio >> SH);
    end
endmodule

// File: rtl/apt_lowest_clear.sv
module apt_lowest_clear #(
    parameter int NW = 4
) (
    input  logic [NW*32-1:0] bank_in,
    output logic [NW*32-1:0] bank_out
);
    always_comb begin
        logic        hit;
        logic [31:0] word;
        bank_out = bank_in;
        hit      = 1'b0;
        for (int w = 0; w < NW; w++) begin
            word = bank_in[w*32 +: 32];
            if (!hit && word != 32'd0) begin
                bank_out[w*32 +: 32] = word & (word - 32'd1);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/apt_prio_scan.sv
module apt_prio_scan
    import apt_pkg::*;
#(
    parameter int MIN_BPR = 0,
    parameter int NW      = 4
) (
    input  logic [NW*32-1:0] levels,
    output logic [8:0]       prio
);
    localparam int SH = MIN_BPR + 1;

    logic [NW-1:0] nz;
    logic [4:0]    tz [NW];

    for (genvar g = 0; g < NW; g++) begin : g_word
        always_comb begin
            nz[g] = |levels[g*32 +: 32];
            tz[g] = 5'd0;
            for (int b = 31; b >= 0; b--) begin
                if (levels[g*32 + b]) tz[g] = 5'(b);
            end
        end
    end

    always_comb begin
        int lvl;
        prio = APT_IDLE;
        lvl  = 0;
        for (int w = NW - 1; w >= 0; w--) begin
            if (nz[w]) begin
                lvl  = w * 32 + int'(tz[w]);
                prio = 9'(lvl << SH);
            end
        end
    end
endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
    import apt_pkg::*;
#(
    parameter int  MIN_BPR = 0,
    parameter int  NUM_IRQ = 64,
    parameter int  ID_W    = 10,
    localparam int NW      = apt_words(MIN_BPR),
    localparam int NB      = NW * 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            groups_en,
    input  logic            common_bpr,
    input  logic [2:0]      bpr_main,
    input  logic [2:0]      bpr_alias,
    input  logic            ack_valid,
    input  logic [7:0]      ack_prio,
    input  logic            ack_group1,
    input  logic            eoi_valid,
    input  logic [ID_W-1:0] eoi_id,
    input  logic            eoi_group1,
    input  logic            eoi_nonsecure,
    output logic [8:0]      run_prio,
    output logic [NB-1:0]   sec_active,
    output logic [NB-1:0]   ns_active
);
    localparam int LVL_W = $clog2(NB);

    typedef struct packed {
        logic [NB-1:0] sec;
        logic [NB-1:0] ns;
        logic [8:0]    rp;
    } state_t;

    state_t q, d;

    logic             ack_grp, eoi_grp, eoi_ok;
    logic [2:0]       bpr_sel;
    logic [7:0]       gprio;
    logic [LVL_W-1:0] level;
    logic [NB-1:0]    eoi_bank, eoi_bank_clr, union_after;
    logic [8:0]       prio_after;

    assign ack_grp  = groups_en & ack_group1;
    assign eoi_grp  = groups_en & eoi_group1;
    assign bpr_sel  = (groups_en && !common_bpr && ack_group1) ? bpr_alias : bpr_main;
    assign eoi_bank = eoi_grp ? q.ns : q.sec;

    apt_group_prio #(.MIN_BPR(MIN_BPR), .LVL_W(LVL_W)) u_gprio (
        .prio  (ack_prio),
        .bpr   (bpr_sel),
        .gprio (gprio),
        .level (level)
    );

    apt_lowest_clear #(.NW(NW)) u_clr (
        .bank_in  (eoi_bank),
        .bank_out (eoi_bank_clr)
    );

    assign union_after = eoi_grp ? (q.sec | eoi_bank_clr) : (eoi_bank_clr | q.ns);

    apt_prio_scan #(.MIN_BPR(MIN_BPR), .NW(NW)) u_scan (
        .levels (union_after),
        .prio   (prio_after)
    );

    always_comb begin
        eoi_ok = eoi_valid
              && (int'(eoi_id) < NUM_IRQ)
              && (q.rp != APT_IDLE)
              && !(eoi_nonsecure && !eoi_grp);
        d = q;
        if (ack_valid) begin
            if (ack_grp) d.ns[level]  = 1'b1;
            else         d.sec[level] = 1'b1;
            d.rp = {1'b0, gprio};
        end else if (eoi_ok) begin
            if (eoi_grp) d.ns  = eoi_bank_clr;
            else         d.sec = eoi_bank_clr;
            d.rp = prio_after;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sec <= '0;
            q.ns  <= '0;
            q.rp  <= APT_IDLE;
        end else begin
            q <= d;
        end
    end

    assign run_prio   = q.rp;
    assign sec_active = q.sec;
    assign ns_active  = q.ns;
endmodule

// File: rtl/apt_tracker_chk.sv
module apt_tracker_chk #(
    parameter int NUM_IRQ = 64,
    parameter int ID_W    = 10,
    parameter int NB      = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            groups_en,
    input logic            ack_valid,
    input logic [7:0]      ack_prio,
    input logic            eoi_valid,
    input logic [ID_W-1:0] eoi_id,
    input logic            eoi_group1,
    input logic            eoi_nonsecure,
    input logic [8:0]      run_prio,
    input logic [NB-1:0]   sec_active,
    input logic [NB-1:0]   ns_active
);
    // R2
    ack_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !run_prio[8] && ((run_prio[7:0] & ~$past(ack_prio)) == 8'd0));

    // R4
    ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> (sec_active | ns_active) != '0);

    // R5
    eoi_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid) |=>
            ((sec_active & ~$past(sec_active)) == '0) && ((ns_active & ~$past(ns_active)) == '0));

    // R5
    eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid) |=>
            ($countones(sec_active) + $countones(ns_active) + 1) >=
            ($past($countones(sec_active)) + $past($countones(ns_active))));

    // R6
    idle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sec_active | ns_active) == '0) == (run_prio == 9'h100));

    // R7
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid && int'(eoi_id) >= NUM_IRQ) |=>
            $stable(run_prio) && $stable(sec_active) && $stable(ns_active));

    // R9
    ns_grp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid && eoi_nonsecure && !(groups_en && eoi_group1)) |=>
            $stable(run_prio) && $stable(sec_active) && $stable(ns_active));
endmodule

bind apt_tracker apt_tracker_chk #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W), .NB(NB)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .groups_en     (groups_en),
    .ack_valid     (ack_valid),
    .ack_prio      (ack_prio),
    .eoi_valid     (eoi_valid),
    .eoi_id        (eoi_id),
    .eoi_group1    (eoi_group1),
    .eoi_nonsecure (eoi_nonsecure),
    .run_prio      (run_prio),
    .sec_active    (sec_active),
    .ns_active     (ns_active)
);

// File: tb/tb_apt_tracker.sv
module tb_apt_tracker;
    localparam int NB = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         groups_en = 1'b0, common_bpr = 1'b0;
    logic [2:0]   bpr_main = 3'd0, bpr_alias = 3'd0;
    logic         ack_valid = 1'b0, ack_group1 = 1'b0;
    logic [7:0]   ack_prio = 8'd0;
    logic         eoi_valid = 1'b0, eoi_group1 = 1'b0, eoi_nonsecure = 1'b0;
    logic [9:0]   eoi_id = 10'd0;
    logic [8:0]   run_prio;
    logic [NB-1:0] sec_active, ns_active;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    logic [NB-1:0] m_sec = '0, m_ns = '0;
    logic [8:0]    m_rp = 9'h100;

    always #4 clk = ~clk;

    apt_tracker dut (
        .clk(clk), .rst_n(rst_n), .groups_en(groups_en), .common_bpr(common_bpr),
        .bpr_main(bpr_main), .bpr_alias(bpr_alias), .ack_valid(ack_valid),
        .ack_prio(ack_prio), .ack_group1(ack_group1), .eoi_valid(eoi_valid),
        .eoi_id(eoi_id), .eoi_group1(eoi_group1), .eoi_nonsecure(eoi_nonsecure),
        .run_prio(run_prio), .sec_active(sec_active), .ns_active(ns_active)
    );

    task automatic chk(string tag, logic [NB-1:0] act, logic [NB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " run_prio"}, NB'(run_prio), NB'(m_rp));
        chk({tag, " sec_active"}, sec_active, m_sec);
        chk({tag, " ns_active"}, ns_active, m_ns);
    endtask

    function automatic int lowest(logic [NB-1:0] v);
        for (int i = 0; i < NB; i++) if (v[i]) return i;
        return -1;
    endfunction

    // model of an acknowledge per R2/R3/R4
    task automatic model_ack(logic [7:0] p, logic g1);
        int b, lvl;
        logic [7:0] gp;
        b  = (groups_en && !common_bpr && g1) ? int'(bpr_alias) : int'(bpr_main);
        gp = p & (8'hFF << (b + 1));
        lvl = int'(gp) >> 1;
        if (groups_en && g1) m_ns[lvl] = 1'b1;
        else                 m_sec[lvl] = 1'b1;
        m_rp = {1'b0, gp};
    endtask

    task automatic do_ack(string tag, logic [7:0] p, logic g1);
        @(negedge clk);
        ack_valid = 1'b1; ack_prio = p; ack_group1 = g1;
        model_ack(p, g1);
        @(negedge clk);
        ack_valid = 1'b0;
        chk_all(tag);
    endtask

    // model of an end-of-interrupt per R5..R9
    task automatic do_eoi(string tag, int id, logic g1, logic ns);
        logic grp;
        int   lo;
        grp = groups_en & g1;
        if (id < 64 && m_rp != 9'h100 && !(ns && !grp)) begin
            if (grp) begin lo = lowest(m_ns);  if (lo >= 0) m_ns[lo] = 1'b0; end
            else     begin lo = lowest(m_sec); if (lo >= 0) m_sec[lo] = 1'b0; end
            lo   = lowest(m_sec | m_ns);
            m_rp = (lo < 0) ? 9'h100 : 9'(lo << 1);
        end
        @(negedge clk);
        eoi_valid = 1'b1; eoi_id = 10'(id); eoi_group1 = g1; eoi_nonsecure = ns;
        @(negedge clk);
        eoi_valid = 1'b0; eoi_nonsecure = 1'b0;
        chk_all(tag);
    endtask

    task automatic t_reset;
        chk_all("R1 reset");
    endtask

    task automatic t_mask;
        groups_en = 0; bpr_main = 3'd0;
        do_ack("R2 bpr0", 8'hA7, 1'b0);            // 0xA6, level 0x53
        do_eoi("R6 drop to idle", 5, 1'b0, 1'b0);
        bpr_main = 3'd2;
        do_ack("R2 bpr2", 8'hA7, 1'b0);            // 0xA0
        do_eoi("R6 drop", 5, 1'b0, 1'b0);
        bpr_main = 3'd7;
        do_ack("R2 bpr7", 8'hFF, 1'b0);            // 0x00, level 0
        do_eoi("R6 drop", 5, 1'b0, 1'b0);
        bpr_main = 3'd0;
    endtask

    task automatic t_alias;
        groups_en = 1; common_bpr = 0; bpr_main = 3'd0; bpr_alias = 3'd3;
        do_ack("R3 alias g1", 8'h5F, 1'b1);        // 0x50 in ns
        do_eoi("R5 g1 eoi", 7, 1'b1, 1'b1);
        do_ack("R3 main g0", 8'h5F, 1'b0);         // 0x5E in sec
        do_eoi("R5 g0 eoi", 7, 1'b0, 1'b0);
        common_bpr = 1;
        do_ack("R3 common g1", 8'h5F, 1'b1);       // 0x5E in ns
        do_eoi("R4 g1 eoi", 7, 1'b1, 1'b0);
        common_bpr = 0; bpr_alias = 3'd0;
    endtask

    task automatic t_nest;
        groups_en = 1; bpr_main = 3'd0; bpr_alias = 3'd0;
        do_ack("R4 nest a", 8'h80, 1'b0);          // sec level 64 (word 2)
        do_ack("R4 nest b", 8'h40, 1'b1);          // ns level 32 (word 1)
        do_ack("R4 nest c", 8'h20, 1'b0);          // sec level 16 (word 0)
        do_eoi("R5 nest pop g0", 3, 1'b0, 1'b0);   // run_prio -> 0x40 from ns
        chk("R6 cross bank", NB'(run_prio), NB'(9'h040));
        do_eoi("R5 nest pop g1", 3, 1'b1, 1'b1);   // -> 0x80
        do_eoi("R6 nest pop last", 3, 1'b0, 1'b0); // -> idle
    endtask

    task automatic t_ignore;
        groups_en = 1;
        do_ack("R7 setup", 8'h30, 1'b0);
        do_eoi("R7 id out of range", 64, 1'b0, 1'b0);
        do_eoi("R7 id max", 1023, 1'b0, 1'b0);
        do_eoi("R9 ns eoi g0", 2, 1'b0, 1'b1);
        do_eoi("R9 secure eoi g0", 2, 1'b0, 1'b0);
        do_eoi("R8 idle eoi", 2, 1'b0, 1'b0);
        chk("R8 still idle", NB'(run_prio), NB'(9'h100));
    endtask

    task automatic t_groups_off;
        groups_en = 0;
        do_ack("R4 groups off g1", 8'h60, 1'b1);   // lands in sec
        do_eoi("R9 groups off ns", 4, 1'b1, 1'b1); // forced group 0: ignored
        do_eoi("R5 groups off sec", 4, 1'b1, 1'b0);
        groups_en = 1;
    endtask

    task automatic t_simul;
        do_ack("R10 setup", 8'h80, 1'b0);
        @(negedge clk);
        ack_valid = 1'b1; ack_prio = 8'h10; ack_group1 = 1'b0;
        eoi_valid = 1'b1; eoi_id = 10'd1; eoi_group1 = 1'b0; eoi_nonsecure = 1'b0;
        model_ack(8'h10, 1'b0);
        @(negedge clk);
        ack_valid = 1'b0; eoi_valid = 1'b0;
        chk_all("R10 ack wins");
        do_eoi("R10 unwind", 1, 1'b0, 1'b0);
        do_eoi("R10 unwind", 1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_alias();
        t_nest();
        t_ignore();
        t_groups_off();
        t_simul();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule